// File: doc/BRIEF.md
# 24-Bit Pixel Pack/Unpack Lane Unit

This block sits in the data path between a master that moves 32-bit pixel words and a frame memory that stores only three bytes per pixel. For each access it decides whether packing applies: packing needs the 12-byte block mode and the pack enable bit of the addressed buffer. Each of the buffers has its own enable bit and its own drop-side bit. On a packed write, one byte lane is discarded (either the top or the bottom one) and the remaining three lanes are shifted down into the low 24 bits of the memory word. The write strobes move with them, and the top strobe is forced low. On a packed read, the three stored bytes are widened back to a 32-bit word, and a programmable fill byte is put in the lane that was dropped.

Every access also carries a mapped flag from the address translator ahead of it. A write to an unmapped location is not forwarded to memory. A read from an unmapped location returns a programmable 32-bit default word, and that word wins over any packing or fill. The block also reports whether packing was applied to each access. The address stage uses this to step 12-byte blocks in memory while the master keeps a 16-byte view. All results come out one clock after the request.

Top module: `pxl_pack_lane`

## Requirements
- R1: After reset, and until the first request, all outputs are zero.
- R2: A request presented at a rising edge produces its result on the outputs after that edge. A cycle without a request gives wr_vld=0, rd_vld=0, acc_packed=0 and zero data, and a write never raises rd_vld in the same cycle.
- R3: Packing is active only when cfg_blk12=1 and the pack enable bit of the addressed buffer is 1. With cfg_blk12=0 the pack enable is ignored. acc_packed reports this decision for every request.
- R4: Buffer index k (req_buf) selects bit k of cfg_pack_en and bit k of cfg_drop_lsb. The other buffers' bits have no effect on the access.
- R5: Packed write with drop bit 0 (top byte dropped): wr_data = {8'h00, wdata[23:0]} and wr_strb = {1'b0, wstrb[2:0]}.
- R6: Packed write with drop bit 1 (bottom byte dropped): wr_data = {8'h00, wdata[31:8]} and wr_strb = {1'b0, wstrb[3:1]}.
- R7: Packed read: with drop bit 0, rd_data = {cfg_fill, mem_rdata[23:0]}. With drop bit 1, rd_data = {mem_rdata[23:0], cfg_fill}.
- R8: Unpacked access: wr_data and wr_strb equal wdata and wstrb, and rd_data equals mem_rdata.
- R9: An unmapped write gives wr_vld=0, wr_data=0 and wr_strb=0. An unmapped read gives rd_vld=1 and rd_data=cfg_dflt, whether or not packing is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_blk12 | input | 1 | 1 selects 12-byte block mode, 0 selects 16-byte mode |
| cfg_pack_en | input | N_BUF | Pack enable, one bit per buffer |
| cfg_drop_lsb | input | N_BUF | Drop side per buffer: 0 drops the top byte, 1 drops the bottom byte |
| cfg_fill | input | LANE_W | Fill byte inserted on packed reads |
| cfg_dflt | input | DW | Word returned by unmapped reads |
| req_vld | input | 1 | Request present |
| req_wr | input | 1 | 1 for write, 0 for read |
| req_buf | input | BUF_W | Buffer index of the access |
| req_mapped | input | 1 | Location is physically mapped |
| req_wdata | input | DW | Master write data |
| req_wstrb | input | N_LANES | Master byte strobes |
| mem_rdata | input | DW | Memory read data (packed pixel in the low lanes) |
| wr_vld | output | 1 | Memory write issued |
| wr_data | output | DW | Memory write data |
| wr_strb | output | N_LANES | Memory byte strobes |
| rd_vld | output | 1 | Read result valid |
| rd_data | output | DW | Read result to the master |
| acc_packed | output | 1 | Packing was applied to the access |

## Verification
The bench writes and reads with distinct byte values in every lane, so the output shows which lane was dropped or filled and in which direction the shift went. Each of these patterns is repeated with 16-byte mode and with the enable cleared, to show that the enable matters only in 12-byte mode. The buffers are given different enable and drop bits, so a wrong index into the per-buffer bits changes the result. Strobe patterns with a single lane set show how the strobes move. Unmapped reads with packing on and off show that the default word takes priority over the fill byte.

// File: rtl/pxl_pack_pkg.sv
package pxl_pack_pkg;
   typedef enum logic {
      DROP_MSB = 1'b0,
      DROP_LSB = 1'b1
   } drop_e;
endpackage

// File: rtl/pxl_mode_sel.sv
module pxl_mode_sel
   import pxl_pack_pkg::*;
#(
   parameter int N_BUF = 4,
   localparam int BUF_W = (N_BUF > 1) ? $clog2(N_BUF) : 1
)(
   input  logic             cfg_blk12,
   input  logic [N_BUF-1:0] cfg_pack_en,
   input  logic [N_BUF-1:0] cfg_drop_lsb,
   input  logic [BUF_W-1:0] buf_idx,
   output logic             packed_o,
   output drop_e            drop_o
);
   logic en_sel;
   logic lsb_sel;

   generate
      if (N_BUF < 1) begin : g_bad
         $error("pxl_mode_sel: N_BUF must be at least 1");
      end
      if (N_BUF == 1) begin : g_single
         assign en_sel  = cfg_pack_en[0];
         assign lsb_sel = cfg_drop_lsb[0];
      end else begin : g_multi
         always_comb begin
            en_sel  = 1'b0;
            lsb_sel = 1'b0;
            if (int'(buf_idx) < N_BUF) begin
               en_sel  = cfg_pack_en[buf_idx];
               lsb_sel = cfg_drop_lsb[buf_idx];
            end
         end
      end
   endgenerate

   assign packed_o = cfg_blk12 & en_sel;
   assign drop_o   = lsb_sel ? DROP_LSB : DROP_MSB;
endmodule

// File: rtl/pxl_wr_packer.sv
module pxl_wr_packer
   import pxl_pack_pkg::*;
#(
   parameter int LANE_W  = 8,
   parameter int N_LANES = 4,
   localparam int DW     = LANE_W * N_LANES
)(
   input  logic               packed_i,
   input  drop_e              drop_i,
   input  logic [DW-1:0]      data_i,
   input  logic [N_LANES-1:0] strb_i,
   output logic [DW-1:0]      data_o,
   output logic [N_LANES-1:0] strb_o
);
   logic [DW-1:0]      pk_data;
   logic [N_LANES-1:0] pk_strb;

   generate
      if (N_LANES < 2) begin : g_bad
         $error("pxl_wr_packer: N_LANES must be at least 2");
      end
      for (genvar i = 0; i < N_LANES - 1; i++) begin : g_lane
         assign pk_data[i*LANE_W +: LANE_W] = (drop_i == DROP_LSB) ?
            data_i[(i+1)*LANE_W +: LANE_W] : data_i[i*LANE_W +: LANE_W];
         assign pk_strb[i] = (drop_i == DROP_LSB) ? strb_i[i+1] : strb_i[i];
      end
   endgenerate

   assign pk_data[(N_LANES-1)*LANE_W +: LANE_W] = '0;
   assign pk_strb[N_LANES-1] = 1'b0;

   assign data_o = packed_i ? pk_data : data_i;
   assign strb_o = packed_i ? pk_strb : strb_i;
endmodule

// File: rtl/pxl_rd_unpacker.sv
module pxl_rd_unpacker
   import pxl_pack_pkg::*;
#(
   parameter int LANE_W  = 8,
   parameter int N_LANES = 4,
   localparam int DW     = LANE_W * N_LANES
)(
   input  logic              packed_i,
   input  drop_e             drop_i,
   input  logic [LANE_W-1:0] fill_i,
   input  logic [DW-1:0]     data_i,
   output logic [DW-1:0]     data_o
);
   logic [DW-1:0] up_data;

   generate
      for (genvar i = 0; i < N_LANES; i++) begin : g_lane
         if (i == 0) begin : g_low
            assign up_data[i*LANE_W +: LANE_W] = (drop_i == DROP_LSB) ?
               fill_i : data_i[i*LANE_W +: LANE_W];
         end else if (i == N_LANES - 1) begin : g_top
            assign up_data[i*LANE_W +: LANE_W] = (drop_i == DROP_LSB) ?
               data_i[(i-1)*LANE_W +: LANE_W] : fill_i;
         end else begin : g_mid
            assign up_data[i*LANE_W +: LANE_W] = (drop_i == DROP_LSB) ?
               data_i[(i-1)*LANE_W +: LANE_W] : data_i[i*LANE_W +: LANE_W];
         end
      end
   endgenerate

   assign data_o = packed_i ? up_data : data_i;
endmodule

// File: rtl/pxl_pack_lane.sv
module pxl_pack_lane
   import pxl_pack_pkg::*;
#(
   parameter int LANE_W  = 8,
   parameter int N_LANES = 4,
   parameter int N_BUF   = 4,
   localparam int DW     = LANE_W * N_LANES,
   localparam int BUF_W  = (N_BUF > 1) ? $clog2(N_BUF) : 1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_blk12,
   input  logic [N_BUF-1:0]   cfg_pack_en,
   input  logic [N_BUF-1:0]   cfg_drop_lsb,
   input  logic [LANE_W-1:0]  cfg_fill,
   input  logic [DW-1:0]      cfg_dflt,
   input  logic               req_vld,
   input  logic               req_wr,
   input  logic [BUF_W-1:0]   req_buf,
   input  logic               req_mapped,
   input  logic [DW-1:0]      req_wdata,
   input  logic [N_LANES-1:0] req_wstrb,
   input  logic [DW-1:0]      mem_rdata,
   output logic               wr_vld,
   output logic [DW-1:0]      wr_data,
   output logic [N_LANES-1:0] wr_strb,
   output logic               rd_vld,
   output logic [DW-1:0]      rd_data,
   output logic               acc_packed
);
   generate
      if (LANE_W < 1) begin : g_bad_lane
         $error("pxl_pack_lane: LANE_W must be at least 1");
      end
      if (N_LANES < 2) begin : g_bad_lanes
         $error("pxl_pack_lane: N_LANES must be at least 2");
      end
   endgenerate

   logic               pk;
   drop_e              drop;
   logic [DW-1:0]      wr_data_nx;
   logic [N_LANES-1:0] wr_strb_nx;
   logic [DW-1:0]      rd_unpk;

   pxl_mode_sel #(.N_BUF(N_BUF)) u_mode (
      .cfg_blk12   (cfg_blk12),
      .cfg_pack_en (cfg_pack_en),
      .cfg_drop_lsb(cfg_drop_lsb),
      .buf_idx     (req_buf),
      .packed_o    (pk),
      .drop_o      (drop)
   );

   pxl_wr_packer #(.LANE_W(LANE_W), .N_LANES(N_LANES)) u_wr (
      .packed_i(pk),
      .drop_i  (drop),
      .data_i  (req_wdata),
      .strb_i  (req_wstrb),
      .data_o  (wr_data_nx),
      .strb_o  (wr_strb_nx)
   );

   pxl_rd_unpacker #(.LANE_W(LANE_W), .N_LANES(N_LANES)) u_rd (
      .packed_i(pk),
      .drop_i  (drop),
      .fill_i  (cfg_fill),
      .data_i  (mem_rdata),
      .data_o  (rd_unpk)
   );

   logic wr_go;
   logic rd_go;
   assign wr_go = req_vld & req_wr & req_mapped;
   assign rd_go = req_vld & ~req_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_vld     <= 1'b0;
         wr_data    <= '0;
         wr_strb    <= '0;
         rd_vld     <= 1'b0;
         rd_data    <= '0;
         acc_packed <= 1'b0;
      end else begin
         wr_vld     <= wr_go;
         wr_data    <= wr_go ? wr_data_nx : '0;
         wr_strb    <= wr_go ? wr_strb_nx : '0;
         rd_vld     <= rd_go;
         rd_data    <= rd_go ? (req_mapped ? rd_unpk : cfg_dflt) : '0;
         acc_packed <= req_vld & pk;
      end
   end

   // R2: a write and a read result never show in the same cycle
   a_r2_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_vld && rd_vld));

   // R2: an idle cycle leaves both valids low after the edge
   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |=> (!wr_vld && !rd_vld && !acc_packed));

   // R9: an unmapped write is not forwarded
   a_r9_drop_unmapped_wr: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && req_wr && !req_mapped) |=> !wr_vld);

   // R9: an unmapped read returns the default word, packing or not
   a_r9_dflt_read: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && !req_wr && !req_mapped) |=> (rd_vld && rd_data == $past(cfg_dflt)));

   // R3: in 16-byte mode no access is packed
   a_r3_no_pack_16: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && !cfg_blk12) |=> !acc_packed);

   // R5 / R6: a packed write never strobes or carries the top lane
   a_r5_top_lane_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_vld && acc_packed) |-> (!wr_strb[N_LANES-1] &&
                                  wr_data[DW-1 -: LANE_W] == '0));

   // R8: an unpacked mapped write passes data and strobes through
   a_r8_pass_write: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && req_wr && req_mapped && !cfg_blk12) |=>
         (wr_data == $past(req_wdata) && wr_strb == $past(req_wstrb)));
endmodule

// File: tb/tb_pxl_pack_lane.sv
module tb_pxl_pack_lane;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_blk12 = 1'b0;
   logic [3:0]  cfg_pack_en = '0;
   logic [3:0]  cfg_drop_lsb = '0;
   logic [7:0]  cfg_fill = '0;
   logic [31:0] cfg_dflt = '0;
   logic        req_vld = 1'b0;
   logic        req_wr = 1'b0;
   logic [1:0]  req_buf = '0;
   logic        req_mapped = 1'b0;
   logic [31:0] req_wdata = '0;
   logic [3:0]  req_wstrb = '0;
   logic [31:0] mem_rdata = '0;
   logic        wr_vld;
   logic [31:0] wr_data;
   logic [3:0]  wr_strb;
   logic        rd_vld;
   logic [31:0] rd_data;
   logic        acc_packed;

   always #4 clk = ~clk;

   pxl_pack_lane dut (
      .clk(clk), .rst_n(rst_n), .cfg_blk12(cfg_blk12), .cfg_pack_en(cfg_pack_en),
      .cfg_drop_lsb(cfg_drop_lsb), .cfg_fill(cfg_fill), .cfg_dflt(cfg_dflt),
      .req_vld(req_vld), .req_wr(req_wr), .req_buf(req_buf), .req_mapped(req_mapped),
      .req_wdata(req_wdata), .req_wstrb(req_wstrb), .mem_rdata(mem_rdata),
      .wr_vld(wr_vld), .wr_data(wr_data), .wr_strb(wr_strb), .rd_vld(rd_vld),
      .rd_data(rd_data), .acc_packed(acc_packed)
   );

   typedef struct {
      string       tag;
      logic        wv;
      logic [31:0] wd;
      logic [3:0]  ws;
      logic        rv;
      logic [31:0] rdd;
      logic        pk;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done = 0;

   bit          nx_blk12;
   logic [3:0]  nx_pe;
   logic [3:0]  nx_pl;
   logic [7:0]  nx_fill;
   logic [31:0] nx_dflt;

   function automatic exp_t model(string tag, bit wr, int b, bit mapped,
                                  logic [31:0] wd, logic [3:0] ws, logic [31:0] md);
      exp_t e;
      bit pk;
      bit lsb;
      pk  = nx_blk12 && nx_pe[b];
      lsb = nx_pl[b];
      e.tag = tag; e.pk = pk;
      e.wv = 0; e.wd = '0; e.ws = '0; e.rv = 0; e.rdd = '0;
      if (wr) begin
         if (mapped) begin
            e.wv = 1;
            if (!pk) begin e.wd = wd; e.ws = ws; end
            else if (lsb) begin e.wd = {8'h00, wd[31:8]}; e.ws = {1'b0, ws[3:1]}; end
            else begin e.wd = {8'h00, wd[23:0]}; e.ws = {1'b0, ws[2:0]}; end
         end
      end else begin
         e.rv = 1;
         if (!mapped) e.rdd = nx_dflt;
         else if (!pk) e.rdd = md;
         else if (lsb) e.rdd = {md[23:0], nx_fill};
         else e.rdd = {nx_fill, md[23:0]};
      end
      return e;
   endfunction

   task automatic drive(string tag, bit wr, int b, bit mapped,
                        logic [31:0] wd, logic [3:0] ws, logic [31:0] md);
      @(negedge clk);
      cfg_blk12 = nx_blk12; cfg_pack_en = nx_pe; cfg_drop_lsb = nx_pl;
      cfg_fill = nx_fill; cfg_dflt = nx_dflt;
      req_vld = 1; req_wr = wr; req_buf = 2'(b); req_mapped = mapped;
      req_wdata = wd; req_wstrb = ws; mem_rdata = md;
      q.push_back(model(tag, wr, b, mapped, wd, ws, md));
   endtask

   task automatic idle(string tag);
      exp_t e;
      @(negedge clk);
      req_vld = 0; req_wdata = 32'hFFFF_FFFF; req_wstrb = 4'hF; mem_rdata = 32'hFFFF_FFFF;
      e.tag = tag; e.wv = 0; e.wd = '0; e.ws = '0; e.rv = 0; e.rdd = '0; e.pk = 0;
      q.push_back(e);
   endtask

   always begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         n_chk++;
         if (wr_vld !== e.wv || wr_data !== e.wd || wr_strb !== e.ws ||
             rd_vld !== e.rv || rd_data !== e.rdd || acc_packed !== e.pk) begin
            n_bad++;
            $display("FAIL %s: got wv=%0b wd=%h ws=%b rv=%0b rd=%h pk=%0b exp wv=%0b wd=%h ws=%b rv=%0b rd=%h pk=%0b",
                     e.tag, wr_vld, wr_data, wr_strb, rd_vld, rd_data, acc_packed,
                     e.wv, e.wd, e.ws, e.rv, e.rdd, e.pk);
         end
      end
   end

   initial begin
      #200000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout exp finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      nx_blk12 = 0; nx_pe = '0; nx_pl = '0; nx_fill = 8'hA5; nx_dflt = 32'hDEAD_BEEF;
      repeat (3) @(posedge clk);
      @(negedge clk);
      n_chk++;
      if (wr_vld !== 0 || rd_vld !== 0 || acc_packed !== 0 || wr_data !== 0 ||
          wr_strb !== 0 || rd_data !== 0) begin
         n_bad++;
         $display("FAIL R1 reset: got wv=%0b rv=%0b pk=%0b wd=%h rd=%h exp all zero",
                  wr_vld, rd_vld, acc_packed, wr_data, rd_data);
      end
      rst_n = 1;
      idle("R1 first idle after reset");

      // 12-byte mode; buffer 0 drops top, 1 drops bottom, 2 disabled, 3 drops bottom
      nx_blk12 = 1; nx_pe = 4'b1011; nx_pl = 4'b1010;
      drive("R5 packed write drop top", 1, 0, 1, 32'h4433_2211, 4'hF, 32'h0);
      drive("R6 packed write drop bottom", 1, 1, 1, 32'h4433_2211, 4'hF, 32'h0);
      drive("R5 strobe shift lane3 only", 1, 0, 1, 32'h8877_6655, 4'b1000, 32'h0);
      drive("R6 strobe shift lane0 only", 1, 1, 1, 32'h8877_6655, 4'b0001, 32'h0);
      drive("R6 strobe shift lane1", 1, 3, 1, 32'hCAFE_F00D, 4'b0010, 32'h0);
      drive("R7 packed read fill top", 0, 0, 1, 32'h0, 4'h0, 32'h99CC_BBAA);
      drive("R7 packed read fill bottom", 0, 1, 1, 32'h0, 4'h0, 32'h99CC_BBAA);
      drive("R4 buffer 2 enable clear passes write", 1, 2, 1, 32'h4433_2211, 4'b0110, 32'h0);
      drive("R4 buffer 2 enable clear passes read", 0, 2, 1, 32'h0, 4'h0, 32'h99CC_BBAA);
      drive("R4 buffer 3 drops bottom", 0, 3, 1, 32'h0, 4'h0, 32'h1234_5678);
      idle("R2 idle gap");
      drive("R9 unmapped write dropped", 1, 0, 0, 32'h4433_2211, 4'hF, 32'h0);
      drive("R9 unmapped packed read default", 0, 1, 0, 32'h0, 4'h0, 32'h99CC_BBAA);
      nx_fill = 8'h3C;
      drive("R7 new fill byte", 0, 0, 1, 32'h0, 4'h0, 32'h00DD_EEFF);

      // 16-byte mode: pack enable ignored
      nx_blk12 = 0; nx_pe = 4'hF;
      drive("R3 16-byte write ignores enable", 1, 0, 1, 32'h4433_2211, 4'b1011, 32'h0);
      drive("R3 16-byte read ignores enable", 0, 1, 1, 32'h0, 4'h0, 32'h99CC_BBAA);
      drive("R8 passthrough write", 1, 3, 1, 32'h0102_0304, 4'b1100, 32'h0);
      nx_dflt = 32'h0BAD_F00D;
      drive("R9 unmapped unpacked read default", 0, 2, 1'b0, 32'h0, 4'h0, 32'h5555_5555);
      drive("R9 unmapped unpacked write dropped", 1, 2, 0, 32'h7777_7777, 4'hF, 32'h0);

      // 12-byte mode with all enables clear
      nx_blk12 = 1; nx_pe = 4'h0;
      drive("R3 12-byte enable clear write", 1, 1, 1, 32'hA1B2_C3D4, 4'hF, 32'h0);
      drive("R8 12-byte enable clear read", 0, 0, 1, 32'h0, 4'h0, 32'hE1E2_E3E4);
      nx_pe = 4'b0100; nx_pl = 4'b0000;
      drive("R4 only buffer 2 packs", 1, 2, 1, 32'hA1B2_C3D4, 4'hF, 32'h0);
      drive("R4 buffer 1 unaffected", 1, 1, 1, 32'hA1B2_C3D4, 4'hF, 32'h0);
      drive("R2 read after write", 0, 2, 1, 32'h0, 4'h0, 32'hF0E0_D0C0);
      idle("R2 trailing idle");
      idle("R2 trailing idle 2");
      repeat (3) @(posedge clk);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule